// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block guards a software-initiated change of the clock frequency. Software first sets the enable bit, then makes the change. The accepted change event starts a countdown. If software does not stop the countdown in time by clearing the enable bit, the block does four things:

- it sets a sticky status flag;
- it can pull a system reset line low for a fixed number of cycles;
- it steers the frequency source to a recovery setting;
- it locks out any further frequency change.

The countdown has a 5-bit length field, counted in units of one of two time bases. The short base is nominally 150 ms and the long base nominally 2.5 s. Both are built from an external base tick by a parameterised divider. The lock stays in place until software clears the enable bit.

Top module: `freq_guard_wdt`

## Requirements
- R1: After reset the status flag is 0, the reset drive is released (`wd_rst_n`=1), the lock is 0 and `rcv_from_nm` is 0.
- R2: A frequency change that arrives while `wd_en` is 0 starts no countdown, so no timeout ever follows from it.
- R3: With `prescale_long`=0, the status flag rises on the clock edge that counts the ((`tmo_field`+1)*SHORT_DIV)-th base tick after the edge that accepted the change. It is still 0 one edge earlier.
- R4: With `prescale_long`=1 the same rule holds with LONG_DIV in place of SHORT_DIV. The prescaler bit is sampled when the change is accepted.
- R5: Only edges with `tick_in`=1 advance the countdown. With `tick_in` held at 0 the status flag never rises.
- R6: The status flag stays 1 until a cycle with `status_clr`=1 clears it. It stays 1 while `status_clr` is 0.
- R7: On timeout with `rst_on_wd_en`=1, `wd_rst_n` is 0 for exactly RST_CYCLES cycles and then returns to 1. With `rst_on_wd_en`=0 it stays 1.
- R8: On timeout `freq_lock` becomes 1. `rcv_from_nm` then shows `rcv_sel` as sampled at the timeout edge: 0 selects the latched strap code, 1 selects the programmed N/M pair.
- R9: While `freq_lock` is 1, `freq_accept` is 0 for any frequency change, and no new countdown starts.
- R10: When `wd_en` is 0 on an edge, the countdown stops, the count reloads and the lock releases. The next accepted change counts the full time again.
- R11: While the lock is 0, `freq_accept` follows `freq_change` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Base tick enable for the time-base divider |
| freq_change | input | 1 | Frequency-change request strobe |
| wd_en | input | 1 | Watchdog enable bit; 0 stops, reloads and unlocks |
| tmo_field | input | 5 | Timeout length minus one, in time-base units |
| prescale_long | input | 1 | Time base: 0 short, 1 long |
| rst_on_wd_en | input | 1 | Pulse the system reset on timeout |
| status_clr | input | 1 | Write-one-to-clear strobe for the status flag |
| rcv_sel | input | 1 | Recovery source: 0 strap code, 1 programmed N/M |
| freq_accept | output | 1 | Frequency change honoured this cycle |
| wd_status | output | 1 | Sticky timeout flag |
| wd_rst_n | output | 1 | Open-drain reset drive enable, active low |
| freq_lock | output | 1 | Recovery lock active |
| rcv_from_nm | output | 1 | Recovery uses programmed N/M (valid while locked) |

## Verification
A vector table sweeps the timeout field from its minimum to its maximum, across both time bases. It also varies the reset-enable and recovery-select bits, so that an off-by-one in the unit count, a swapped divider, or a wrongly sampled recovery source each moves the status edge or the flags.

Directed runs cover the remaining behaviours:
- gated ticks, which separate counting base ticks from counting clock cycles;
- a change while disabled, and a change while locked, which test the arming conditions;
- a stop before expiry followed by a fresh change, which shows whether the count truly reloads.

// File: rtl/freq_guard_wdt.sv
module freq_guard_wdt #(
  parameter int SHORT_DIV  = 3,
  parameter int LONG_DIV   = 50,
  parameter int RST_CYCLES = 8,
  parameter int TMO_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             freq_change,
  input  logic             wd_en,
  input  logic [TMO_W-1:0] tmo_field,
  input  logic             prescale_long,
  input  logic             rst_on_wd_en,
  input  logic             status_clr,
  input  logic             rcv_sel,
  output logic             freq_accept,
  output logic             wd_status,
  output logic             wd_rst_n,
  output logic             freq_lock,
  output logic             rcv_from_nm
);
  localparam int DIV_MAX = (LONG_DIV > SHORT_DIV) ? LONG_DIV : SHORT_DIV;
  localparam int DIV_W   = $clog2(DIV_MAX) + 1;
  localparam int UNIT_W  = TMO_W + 1;
  localparam int RST_W   = $clog2(RST_CYCLES + 1);

  logic              running, lock_q, status_q, long_q, nm_q;
  logic [DIV_W-1:0]  sub_cnt;
  logic [UNIT_W-1:0] units_left;
  logic [RST_W-1:0]  rst_cnt;

  wire [DIV_W-1:0]  div_last = long_q ? DIV_W'(LONG_DIV - 1) : DIV_W'(SHORT_DIV - 1);
  wire [UNIT_W-1:0] load_val = UNIT_W'(tmo_field) + UNIT_W'(1);
  wire              arm      = freq_accept & wd_en;
  wire              unit_end = running & tick_in & (sub_cnt == div_last);
  wire              expire   = unit_end & (units_left == UNIT_W'(1));

  assign freq_accept = freq_change & ~lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running    <= 1'b0;
      lock_q     <= 1'b0;
      long_q     <= 1'b0;
      nm_q       <= 1'b0;
      sub_cnt    <= '0;
      units_left <= '0;
    end else if (!wd_en) begin
      running    <= 1'b0;
      lock_q     <= 1'b0;
      sub_cnt    <= '0;
      units_left <= load_val;
    end else if (arm) begin
      running    <= 1'b1;
      long_q     <= prescale_long;
      sub_cnt    <= '0;
      units_left <= load_val;
    end else if (running && tick_in) begin
      if (unit_end) begin
        sub_cnt <= '0;
        if (expire) begin
          running <= 1'b0;
          lock_q  <= 1'b1;
          nm_q    <= rcv_sel;
        end else begin
          units_left <= units_left - UNIT_W'(1);
        end
      end else begin
        sub_cnt <= sub_cnt + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          status_q <= 1'b0;
    else if (expire)     status_q <= 1'b1;
    else if (status_clr) status_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rst_cnt <= '0;
    else if (expire && rst_on_wd_en) rst_cnt <= RST_W'(RST_CYCLES);
    else if (rst_cnt != '0)          rst_cnt <= rst_cnt - RST_W'(1);
  end

  assign wd_status   = status_q;
  assign wd_rst_n    = (rst_cnt == '0);
  assign freq_lock   = lock_q;
  assign rcv_from_nm = lock_q & nm_q;
endmodule

// File: rtl/freq_guard_wdt_chk.sv
module freq_guard_wdt_chk (
  input logic clk,
  input logic rst_n,
  input logic wd_en,
  input logic status_clr,
  input logic rst_on_wd_en,
  input logic freq_accept,
  input logic wd_status,
  input logic wd_rst_n,
  input logic freq_lock
);
  a_r7_rst_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst_n) |-> $past(rst_on_wd_en));

  a_r8_lock_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freq_lock) |-> wd_status);

  a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_status && !status_clr) |=> wd_status);

  a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_lock && wd_en) |=> freq_lock);

  a_r10_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> !freq_lock);

  a_r9_locked_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_lock && wd_en) |=> !freq_accept);
endmodule

bind freq_guard_wdt freq_guard_wdt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .status_clr(status_clr),
  .rst_on_wd_en(rst_on_wd_en), .freq_accept(freq_accept),
  .wd_status(wd_status), .wd_rst_n(wd_rst_n), .freq_lock(freq_lock)
);

// File: tb/sim_freq_guard_wdt.sv
`timescale 1ns/1ps
module sim_freq_guard_wdt;
  localparam int SD = 3, LD = 50, RC = 8, NV = 6;
  localparam int V_FIELD [NV] = '{0, 1, 5, 31, 0, 2};
  localparam int V_LONG  [NV] = '{0, 0, 0, 0, 1, 1};
  localparam int V_RST   [NV] = '{1, 0, 1, 0, 1, 0};
  localparam int V_SEL   [NV] = '{0, 1, 1, 0, 0, 1};

  logic clk = 0, rst_n = 0, tick_in = 1, freq_change = 0, wd_en = 0;
  logic [4:0] tmo_field = 5'd31;
  logic prescale_long = 0, rst_on_wd_en = 0, status_clr = 0, rcv_sel = 0;
  logic freq_accept, wd_status, wd_rst_n, freq_lock, rcv_from_nm;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  freq_guard_wdt #(.SHORT_DIV(SD), .LONG_DIV(LD), .RST_CYCLES(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .freq_change(freq_change),
    .wd_en(wd_en), .tmo_field(tmo_field), .prescale_long(prescale_long),
    .rst_on_wd_en(rst_on_wd_en), .status_clr(status_clr), .rcv_sel(rcv_sel),
    .freq_accept(freq_accept), .wd_status(wd_status), .wd_rst_n(wd_rst_n),
    .freq_lock(freq_lock), .rcv_from_nm(rcv_from_nm));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_change();
    freq_change = 1; cyc(1); freq_change = 0;
  endtask

  task automatic clear_status();
    status_clr = 1; cyc(1); status_clr = 0;
  endtask

  task automatic restart();
    wd_en = 0; cyc(1); clear_status(); wd_en = 1;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(2);
    chk("R1 status", wd_status, 0);
    chk("R1 rst drive", wd_rst_n, 1);
    chk("R1 lock", freq_lock, 0);
    chk("R1 nm", rcv_from_nm, 0);
    rst_n = 1; cyc(1);

    // R2 / R11: change while disabled
    freq_change = 1; #1;
    chk("R11 accept unlocked", freq_accept, 1);
    cyc(1); freq_change = 0;
    cyc(200);
    chk("R2 no timeout when disabled", wd_status, 0);
    chk("R2 no lock when disabled", freq_lock, 0);

    // R3/R4/R7/R8 vector table
    for (int i = 0; i < NV; i++) begin
      int exp_c;
      tmo_field = 5'(V_FIELD[i]); prescale_long = V_LONG[i][0];
      rst_on_wd_en = V_RST[i][0]; rcv_sel = V_SEL[i][0];
      restart();
      exp_c = (V_FIELD[i] + 1) * (V_LONG[i] != 0 ? LD : SD);
      pulse_change();
      cyc(exp_c - 1);
      chk(V_LONG[i] != 0 ? "R4 before expiry" : "R3 before expiry", wd_status, 0);
      cyc(1);
      chk(V_LONG[i] != 0 ? "R4 at expiry" : "R3 at expiry", wd_status, 1);
      chk("R8 lock", freq_lock, 1);
      chk("R8 recovery source", rcv_from_nm, V_SEL[i]);
      chk("R7 reset drive", wd_rst_n, V_RST[i] != 0 ? 0 : 1);
      cyc(RC - 1);
      chk("R7 reset width", wd_rst_n, V_RST[i] != 0 ? 0 : 1);
      cyc(1);
      chk("R7 reset released", wd_rst_n, 1);
    end

    // R6 sticky then clear; R9 locked refusal
    cyc(50);
    chk("R6 sticky", wd_status, 1);
    clear_status();
    chk("R6 cleared", wd_status, 0);
    tmo_field = 5'd0; prescale_long = 0;
    freq_change = 1; #1;
    chk("R9 refused while locked", freq_accept, 0);
    cyc(1); freq_change = 0;
    cyc(20);
    chk("R9 no new timeout", wd_status, 0);
    chk("R9 still locked", freq_lock, 1);

    // R10: unlock on disable, stop and reload
    wd_en = 0; cyc(1);
    chk("R10 unlock", freq_lock, 0);
    chk("R10 nm cleared", rcv_from_nm, 0);
    tmo_field = 5'd1; rst_on_wd_en = 0; wd_en = 1;
    pulse_change(); cyc(3);
    wd_en = 0; cyc(1); wd_en = 1;
    cyc(20);
    chk("R10 stopped timer", wd_status, 0);
    pulse_change(); cyc(2 * SD - 1);
    chk("R10 full reload before", wd_status, 0);
    cyc(1);
    chk("R10 full reload at", wd_status, 1);

    // R5: gated ticks
    tmo_field = 5'd0; restart();
    tick_in = 0;
    pulse_change(); cyc(40);
    chk("R5 no ticks no timeout", wd_status, 0);
    tick_in = 1; cyc(SD - 1);
    chk("R5 before last tick", wd_status, 0);
    cyc(1);
    chk("R5 after last tick", wd_status, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule